// File: doc/BRIEF.md
# Pipelined No-Turnaround Synchronous SRAM

This block is a synthesizable behavioural model of a pipelined synchronous static RAM that accepts one operation on every clock edge. Reads and writes may follow each other in any order with no idle cycle between them when the data bus changes direction. Every operation takes the same two enabled clock edges, so the data bus carries read data and write data in the same slot of the pipeline. A write's data and lane enables arrive two enabled edges after its address. The write is then parked in a holding register and stored in the array at the next enabled edge. A read that meets the parked write takes the new lanes from the holding register.

A command is selected through three chip selects and a single read/write strobe. A burst-advance input continues the current access through a two-bit burst counter, in linear or interleaved order as chosen by a static strap. A clock enable freezes the whole pipeline. The output enable and the sleep input gate the data-bus drive without waiting for a clock. The bidirectional data bus is split into an input port, an output port and an output drive enable.

Top module: `pipe_sram`

## Requirements
- R1: An operation starts at an enabled edge only when cs_a=1, cs_b_n=0, cs_c=1 and burst_adv=0. At that edge we=1 selects a write and we=0 selects a read. Any other chip-select pattern with burst_adv=0 is a deselect and does nothing.
- R2: Read data for an address taken at enabled edge k is driven on d_out with d_oe=1 after enabled edge k+2, and it stays there until the next enabled edge.
- R3: The data and lane enables of a write taken at enabled edge k are sampled from d_in and lane_we at enabled edge k+2. Lane i is bits [9i+8:9i]. Only lanes with lane_we[i]=1 change.
- R4: Reads and writes may be mixed on consecutive enabled edges. A read always returns the contents left by every write taken before it, including a write taken one edge earlier.
- R5: burst_adv=1 at an enabled edge that follows a started operation or a burst step continues the burst. The step uses the next burst address and repeats the first operation's type, whatever the chip selects are. Address bits above bit 1 keep the loaded value.
- R6: For burst step n (n = 1, 2, 3, then 0 again), the low two address bits are base+n modulo 4 when order_ilv=0, and base XOR n when order_ilv=1.
- R7: burst_adv=1 with no burst in progress (after a deselect or after reset) does nothing. A deselect or an idle edge at enabled edge k leaves d_oe=0 after enabled edge k+2.
- R8: An edge with clk_en=0 is ignored entirely. Pipeline, burst state, d_out and the drive state hold, and nothing is sampled from any input.
- R9: out_en=0 forces d_oe=0 at once, without waiting for a clock edge.
- R10: sleep=1 forces d_oe=0 at once. Edges during sleep are ignored as with clk_en=0, so operations presented then have no effect and the array keeps its contents.
- R11: rst_n=0 at an edge (with clk_en=1) clears the pipeline and the burst state and leaves d_oe=0. The array contents survive reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| clk_en | input | 1 | Clock enable; 0 freezes the device for that edge |
| sleep | input | 1 | Asynchronous sleep request, active high |
| cs_a | input | 1 | Chip select, active high |
| cs_b_n | input | 1 | Chip select, active low |
| cs_c | input | 1 | Chip select, active high |
| we | input | 1 | Operation strobe: 1 write, 0 read |
| burst_adv | input | 1 | Continue current burst at next address |
| order_ilv | input | 1 | Static strap: 1 interleaved, 0 linear burst order |
| out_en | input | 1 | Asynchronous output enable, active high |
| addr | input | ADDR_W | Word address |
| lane_we | input | LANES | Per-lane write enables, sampled with write data |
| d_in | input | LANES*LANE_W | Write data (bus input side) |
| d_out | output | LANES*LANE_W | Read data (bus output side) |
| d_oe | output | 1 | Data bus drive enable |

## Verification
Every operation resolves exactly two enabled edges after its address is taken. Write data is driven in the cycle just before that second edge, and the matching read result is sampled half a cycle after it. The bench keeps its own two-stage copy of the command pipeline, advanced only on edges with clk_en=1 and sleep=0. This lets suspended and sleeping cycles shift every due point by exactly the number of frozen edges. Drive-enable and data checks run at every falling edge against the expectation left by the last enabled edge, and the current out_en and sleep values gate the expected drive with no delay.

// File: rtl/pipe_sram_pkg.sv
// Package: shared types and the burst address rule of the pipelined SRAM.
// Assumes a two-bit burst counter acting on the lowest address bits.
package pipe_sram_pkg;

    localparam int BURST_W = 2;

    typedef enum logic [0:0] {
        OP_READ  = 1'b0,
        OP_WRITE = 1'b1
    } op_e;

    // Low address bits for burst step cnt: XOR when interleaved, add when linear.
    function automatic logic [BURST_W-1:0] burst_low(
        input logic [BURST_W-1:0] base,
        input logic [BURST_W-1:0] cnt,
        input logic               ilv
    );
        return ilv ? (base ^ cnt) : (base + cnt);
    endfunction

endpackage

// File: rtl/pipe_sram_burst.sv
// Command decode and burst counter.
// Turns the sampled control inputs into the command that enters pipeline
// stage 1. It starts a new access on a full chip select, continues the
// running burst on burst_adv, and deselects otherwise.
// Assumes ADDR_W > BURST_W and that order_ilv is static.
module pipe_sram_burst
    import pipe_sram_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              sel_all,
    input  logic              burst_adv,
    input  logic              we,
    input  logic              order_ilv,
    input  logic [ADDR_W-1:0] addr,
    output logic              cmd_valid,
    output op_e               cmd_op,
    output logic [ADDR_W-1:0] cmd_addr
);

    logic               live;
    op_e                live_op;
    logic [ADDR_W-1:0]  base;
    logic [BURST_W-1:0] cnt;
    logic [BURST_W-1:0] cnt_nxt;
    logic               fresh;
    logic               cont;

    // Decode: new access, burst step or deselect, and the address used.
    always_comb begin
        fresh     = sel_all & ~burst_adv;
        cont      = burst_adv & live;
        cnt_nxt   = cnt + BURST_W'(1);
        cmd_valid = fresh | cont;
        cmd_op    = fresh ? (we ? OP_WRITE : OP_READ) : live_op;
        cmd_addr  = fresh ? addr
                          : {base[ADDR_W-1:BURST_W], burst_low(base[BURST_W-1:0], cnt_nxt, order_ilv)};
    end

    // Burst state: loaded on a new access, stepped on advance, dropped on deselect.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live    <= 1'b0;
            live_op <= OP_READ;
            base    <= '0;
            cnt     <= '0;
        end else if (step) begin
            if (fresh) begin
                live    <= 1'b1;
                live_op <= we ? OP_WRITE : OP_READ;
                base    <= addr;
                cnt     <= '0;
            end else if (cont) begin
                cnt <= cnt_nxt;
            end else begin
                live <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/pipe_sram_store.sv
// Storage array with a one-entry write holding register.
// A write accepted at an enabled edge is parked. Its lanes are stored at
// the next enabled edge. Reads merge the parked lanes over the array word
// so a read right behind a write sees the new data.
// Assumes a read and a write are never presented at the same edge.
module pipe_sram_store #(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    step,
    input  logic                    wr_valid,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [LANES*LANE_W-1:0] wr_data,
    input  logic [LANES-1:0]        wr_lanes,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [LANES*LANE_W-1:0] rd_data
);

    localparam int DEPTH  = 1 << ADDR_W;
    localparam int DATA_W = LANES * LANE_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic              hold_v;
    logic [ADDR_W-1:0] hold_addr;
    logic [DATA_W-1:0] hold_data;
    logic [LANES-1:0]  hold_lanes;
    logic              hit;

    // Commit the parked write lane by lane at the next enabled edge.
    always_ff @(posedge clk) begin
        if (step && hold_v) begin
            for (int l = 0; l < LANES; l++) begin
                if (hold_lanes[l]) begin
                    mem[hold_addr][l*LANE_W +: LANE_W] <= hold_data[l*LANE_W +: LANE_W];
                end
            end
        end
    end

    // Holding register: takes the new write, or empties after committing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_v     <= 1'b0;
            hold_addr  <= '0;
            hold_data  <= '0;
            hold_lanes <= '0;
        end else if (step) begin
            hold_v <= wr_valid;
            if (wr_valid) begin
                hold_addr  <= wr_addr;
                hold_data  <= wr_data;
                hold_lanes <= wr_lanes;
            end
        end
    end

    // Address match between the read and the parked write.
    always_comb hit = hold_v && (hold_addr == rd_addr);

    // Per-lane forwarding from the holding register.
    for (genvar g = 0; g < LANES; g++) begin : g_fwd
        always_comb begin
            rd_data[g*LANE_W +: LANE_W] = (hit && hold_lanes[g])
                                        ? hold_data[g*LANE_W +: LANE_W]
                                        : mem[rd_addr][g*LANE_W +: LANE_W];
        end
    end

endmodule

// File: rtl/pipe_sram_out.sv
// Output register and bus drive gating.
// Captures read data at the enabled edge where a read leaves stage 2. The
// drive enable is registered and then gated with the asynchronous output
// enable and sleep inputs.
module pipe_sram_out #(
    parameter int DATA_W = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              rd_fire,
    input  logic [DATA_W-1:0] rd_data,
    input  logic              out_en,
    input  logic              sleep,
    output logic [DATA_W-1:0] q,
    output logic              drive_q,
    output logic              d_oe
);

    // Output register: loads on a read, keeps the last data otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q       <= '0;
            drive_q <= 1'b0;
        end else if (step) begin
            drive_q <= rd_fire;
            if (rd_fire) begin
                q <= rd_data;
            end
        end
    end

    // Asynchronous drive gating.
    always_comb d_oe = drive_q & out_en & ~sleep;

endmodule

// File: rtl/pipe_sram.sv
// Top of the pipelined no-turnaround SRAM.
// Two pipeline stages carry every command. A write takes its data at the
// edge that moves it out of stage 2, and a read takes its data from the
// array at that same edge. Back-to-back reads and writes therefore never
// collide on the data bus. clk_en and sleep freeze every register.
// Assumes order_ilv is changed only while reset is held.
module pipe_sram
    import pipe_sram_pkg::*;
#(
    parameter  int ADDR_W = 8,
    parameter  int LANES  = 4,
    parameter  int LANE_W = 9,
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en,
    input  logic              sleep,
    input  logic              cs_a,
    input  logic              cs_b_n,
    input  logic              cs_c,
    input  logic              we,
    input  logic              burst_adv,
    input  logic              order_ilv,
    input  logic              out_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANES-1:0]  lane_we,
    input  logic [DATA_W-1:0] d_in,
    output logic [DATA_W-1:0] d_out,
    output logic              d_oe
);

    logic              step;
    logic              sel_all;
    logic              cmd_valid;
    op_e               cmd_op;
    logic [ADDR_W-1:0] cmd_addr;
    logic              s1_valid;
    op_e               s1_op;
    logic [ADDR_W-1:0] s1_addr;
    logic              s2_valid;
    op_e               s2_op;
    logic [ADDR_W-1:0] s2_addr;
    logic              wr_valid;
    logic              rd_fire;
    logic [DATA_W-1:0] rd_data;
    logic              drive_q;

    // Edge qualification and chip-select decode.
    always_comb begin
        step    = clk_en & ~sleep;
        sel_all = cs_a & ~cs_b_n & cs_c;
    end

    pipe_sram_burst #(.ADDR_W(ADDR_W)) u_burst (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (step),
        .sel_all   (sel_all),
        .burst_adv (burst_adv),
        .we        (we),
        .order_ilv (order_ilv),
        .addr      (addr),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_addr  (cmd_addr)
    );

    // Two-stage command pipeline.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_op    <= OP_READ;
            s1_addr  <= '0;
            s2_valid <= 1'b0;
            s2_op    <= OP_READ;
            s2_addr  <= '0;
        end else if (step) begin
            s1_valid <= cmd_valid;
            s1_op    <= cmd_op;
            s1_addr  <= cmd_addr;
            s2_valid <= s1_valid;
            s2_op    <= s1_op;
            s2_addr  <= s1_addr;
        end
    end

    // Stage 2 resolves as a write (bus data in) or a read (array data out).
    always_comb begin
        wr_valid = s2_valid && (s2_op == OP_WRITE);
        rd_fire  = s2_valid && (s2_op == OP_READ);
    end

    pipe_sram_store #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (step),
        .wr_valid (wr_valid),
        .wr_addr  (s2_addr),
        .wr_data  (d_in),
        .wr_lanes (lane_we),
        .rd_addr  (s2_addr),
        .rd_data  (rd_data)
    );

    pipe_sram_out #(.DATA_W(DATA_W)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (step),
        .rd_fire (rd_fire),
        .rd_data (rd_data),
        .out_en  (out_en),
        .sleep   (sleep),
        .q       (d_out),
        .drive_q (drive_q),
        .d_oe    (d_oe)
    );

endmodule

// File: rtl/pipe_sram_chk.sv
// Assertion checker for pipe_sram, attached by bind.
module pipe_sram_chk
    import pipe_sram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 36
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clk_en,
    input logic              sleep,
    input logic              cs_a,
    input logic              cs_b_n,
    input logic              cs_c,
    input logic              burst_adv,
    input logic              out_en,
    input logic [DATA_W-1:0] d_out,
    input logic              d_oe,
    input logic              s1_valid,
    input logic [ADDR_W-1:0] s1_addr,
    input logic              s2_valid,
    input op_e               s2_op,
    input logic              drive_q
);

    logic live_edge;
    logic desel;
    always_comb begin
        live_edge = clk_en & ~sleep;
        desel     = ~(cs_a & ~cs_b_n & cs_c) & ~burst_adv;
    end

    assert_oe_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en |-> !d_oe);

    assert_sleep_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> !d_oe);

    assert_suspend_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> $stable(d_out) && $stable(drive_q));

    assert_read_drive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        live_edge && s2_valid && (s2_op == OP_READ) |=> drive_q);

    assert_idle_no_drive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        live_edge && !s2_valid |=> !drive_q);

    assert_deselect_R1: assert property (@(posedge clk) disable iff (!rst_n)
        live_edge && desel |=> !s1_valid);

    assert_burst_upper_R5: assert property (@(posedge clk) disable iff (!rst_n)
        live_edge && burst_adv && s1_valid |=>
            s1_valid && (s1_addr[ADDR_W-1:BURST_W] == $past(s1_addr[ADDR_W-1:BURST_W])));

endmodule

bind pipe_sram pipe_sram_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clk_en    (clk_en),
    .sleep     (sleep),
    .cs_a      (cs_a),
    .cs_b_n    (cs_b_n),
    .cs_c      (cs_c),
    .burst_adv (burst_adv),
    .out_en    (out_en),
    .d_out     (d_out),
    .d_oe      (d_oe),
    .s1_valid  (s1_valid),
    .s1_addr   (s1_addr),
    .s2_valid  (s2_valid),
    .s2_op     (s2_op),
    .drive_q   (drive_q)
);

// File: tb/test_pipe_sram.sv
`timescale 1ns/1ps
module test_pipe_sram;

    localparam int AW = 8;
    localparam int LN = 4;
    localparam int LW = 9;
    localparam int DW = LN * LW;
    localparam logic [2:0] SEL = 3'b101;  // {cs_a, cs_b_n, cs_c} all active

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst_n = 1'b0, clk_en = 1'b1, sleep = 1'b0;
    logic          cs_a = 1'b0, cs_b_n = 1'b1, cs_c = 1'b0;
    logic          we = 1'b0, burst_adv = 1'b0, order_ilv = 1'b0, out_en = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [LN-1:0] lane_we = '0;
    logic [DW-1:0] d_in = '0;
    logic [DW-1:0] d_out;
    logic          d_oe;

    pipe_sram #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW)) i_pipe_sram (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .sleep(sleep),
        .cs_a(cs_a), .cs_b_n(cs_b_n), .cs_c(cs_c), .we(we),
        .burst_adv(burst_adv), .order_ilv(order_ilv), .out_en(out_en),
        .addr(addr), .lane_we(lane_we), .d_in(d_in),
        .d_out(d_out), .d_oe(d_oe)
    );

    // Reference state
    logic [DW-1:0] ref_mem [1 << AW];
    bit            p1v, p1w, p2v, p2w, bl, bw;
    logic [AW-1:0] p1a, p2a, bbase;
    logic [1:0]    bcnt;
    bit            exp_drive;
    logic [DW-1:0] exp_data;
    int            checks = 0, fails = 0;
    string         tag = "R11";
    bit            done = 1'b0;

    function automatic logic [DW-1:0] rnd_word();
        return {4'($urandom), $urandom};
    endfunction

    // Burst address per R6.
    function automatic logic [AW-1:0] step_addr(logic [AW-1:0] b, logic [1:0] n, bit ilv);
        logic [1:0] lo;
        lo = ilv ? (b[1:0] ^ n) : (b[1:0] + n);
        return {b[AW-1:2], lo};
    endfunction

    // Advance the reference by one edge.
    task automatic model_edge();
        if (!rst_n) begin
            p1v = 0; p2v = 0; bl = 0; bcnt = 0; exp_drive = 0;
        end else if (clk_en && !sleep) begin
            if (p2v && p2w) begin
                for (int l = 0; l < LN; l++)
                    if (lane_we[l]) ref_mem[p2a][l*LW +: LW] = d_in[l*LW +: LW];
                exp_drive = 0;
            end else if (p2v) begin
                exp_data  = ref_mem[p2a];
                exp_drive = 1;
            end else begin
                exp_drive = 0;
            end
            p2v = p1v; p2w = p1w; p2a = p1a;
            if ({cs_a, cs_b_n, cs_c} == SEL && !burst_adv) begin
                p1v = 1; p1w = we; p1a = addr;
                bl = 1; bw = we; bbase = addr; bcnt = 0;
            end else if (burst_adv && bl) begin
                bcnt = bcnt + 2'd1;
                p1v = 1; p1w = bw; p1a = step_addr(bbase, bcnt, order_ilv);
            end else begin
                p1v = 0; bl = 0;
            end
        end
    endtask

    // One clock: drive at falling edge, model at rising edge, check at next falling edge.
    task automatic cycle(bit en, bit slp, logic [2:0] cs, bit wr, bit adv,
                         logic [AW-1:0] a, bit oe, logic [DW-1:0] d, logic [LN-1:0] ln);
        bit exp_oe;
        clk_en = en; sleep = slp; {cs_a, cs_b_n, cs_c} = cs; we = wr;
        burst_adv = adv; addr = a; out_en = oe; d_in = d; lane_we = ln;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        exp_oe = exp_drive && oe && !slp;
        checks++;
        if (d_oe !== exp_oe) begin
            fails++;
            $display("FAIL %s: d_oe=%0b expected %0b at %0t", tag, d_oe, exp_oe, $time);
        end
        if (exp_oe) begin
            checks++;
            if (d_out !== exp_data) begin
                fails++;
                $display("FAIL %s: d_out=%h expected %h at %0t", tag, d_out, exp_data, $time);
            end
        end
    endtask

    task automatic idle(int n, logic [DW-1:0] d, logic [LN-1:0] ln);
        for (int i = 0; i < n; i++) cycle(1, 0, 3'b000, 0, 0, '0, 1, d, ln);
    endtask

    task automatic do_reset(bit ilv);
        rst_n = 1'b0;
        idle(1, '0, '0);
        order_ilv = ilv;
        idle(1, '0, '0);
        rst_n = 1'b1;
    endtask

    task automatic rand_cycle();
        logic [2:0] cs;
        logic [AW-1:0] a;
        cs = ($urandom_range(0, 9) < 7) ? SEL : 3'($urandom);
        a  = {AW'($urandom_range(0, 3)) << 4} | AW'($urandom_range(0, 15));
        cycle($urandom_range(0, 9) != 0, $urandom_range(0, 19) == 0, cs,
              1'($urandom), $urandom_range(0, 9) < 3, a,
              $urandom_range(0, 9) != 0, rnd_word(), 4'($urandom));
    endtask

    initial begin
        void'($urandom(32'd9071));
        do_reset(0);
        // R11: pipeline empty after reset
        tag = "R11"; idle(3, '0, '0);

        // Preload every word with full-lane writes (R3).
        tag = "R3";
        for (int a = 0; a < (1 << AW); a++) cycle(1, 0, SEL, 1, 0, AW'(a), 1, rnd_word(), '1);
        idle(3, rnd_word(), '1);

        // R2: single read, then idle.
        tag = "R2"; cycle(1, 0, SEL, 0, 0, 8'h07, 1, '0, '0); idle(3, '0, '0);

        // R3 R4: partial-lane write, read on the very next edge.
        tag = "R4";
        cycle(1, 0, SEL, 1, 0, 8'h05, 1, '0, '0);
        cycle(1, 0, SEL, 0, 0, 8'h05, 1, '0, '0);
        cycle(1, 0, 3'b000, 0, 0, '0, 1, 36'h1_2345_6789, 4'b0101);
        idle(3, '0, '0);

        // R4: write/read alternation.
        cycle(1, 0, SEL, 1, 0, 8'h20, 1, '0, '0);
        cycle(1, 0, SEL, 0, 0, 8'h20, 1, '0, '0);
        cycle(1, 0, SEL, 1, 0, 8'h21, 1, 36'hA_AAAA_AAAA, 4'b1111);
        cycle(1, 0, SEL, 0, 0, 8'h21, 1, '0, '0);
        cycle(1, 0, 3'b000, 0, 0, '0, 1, 36'h5_5555_5555, 4'b1111);
        idle(3, '0, '0);

        // R1: every chip-select pattern with a read.
        tag = "R1";
        for (int c = 0; c < 8; c++) cycle(1, 0, 3'(c), 0, 0, 8'h30 + AW'(c), 1, '0, '0);
        idle(3, '0, '0);

        // R5 R6: linear read burst from low bits 2, chip selects inactive while advancing.
        tag = "R6";
        cycle(1, 0, SEL, 0, 0, 8'h32, 1, '0, '0);
        cycle(1, 0, 3'b000, 0, 1, 8'hFF, 1, '0, '0);
        cycle(1, 0, 3'b010, 1, 1, 8'h00, 1, '0, '0);
        cycle(1, 0, 3'b000, 0, 1, '0, 1, '0, '0);
        cycle(1, 0, 3'b000, 0, 1, '0, 1, '0, '0);
        idle(3, '0, '0);

        // R5: write burst, data streamed two edges behind, then read burst back.
        tag = "R5";
        cycle(1, 0, SEL, 1, 0, 8'h45, 1, '0, '0);
        cycle(1, 0, 3'b000, 0, 1, '0, 1, '0, '0);
        cycle(1, 0, 3'b000, 0, 1, '0, 1, 36'h1_1111_1111, 4'b1111);
        cycle(1, 0, 3'b000, 0, 0, '0, 1, 36'h2_2222_2222, 4'b1100);
        cycle(1, 0, 3'b000, 0, 0, '0, 1, 36'h3_3333_3333, 4'b0011);
        cycle(1, 0, SEL, 0, 0, 8'h45, 1, '0, '0);
        cycle(1, 0, 3'b000, 0, 1, '0, 1, '0, '0);
        cycle(1, 0, 3'b000, 0, 1, '0, 1, '0, '0);
        idle(3, '0, '0);

        // R7: advance with no burst running; read followed by deselect.
        tag = "R7";
        cycle(1, 0, 3'b000, 0, 1, 8'h10, 1, '0, '0);
        cycle(1, 0, 3'b000, 0, 1, 8'h10, 1, '0, '0);
        cycle(1, 0, SEL, 0, 0, 8'h11, 1, '0, '0);
        idle(4, '0, '0);

        // R8: suspend in the middle of a burst, with junk on the bus.
        tag = "R8";
        cycle(1, 0, SEL, 0, 0, 8'h33, 1, '0, '0);
        cycle(0, 0, SEL, 1, 0, 8'h05, 1, rnd_word(), '1);
        cycle(1, 0, 3'b000, 0, 1, '0, 1, '0, '0);
        cycle(0, 0, 3'b000, 0, 1, '0, 1, rnd_word(), '1);
        cycle(0, 0, SEL, 1, 0, 8'h33, 1, rnd_word(), '1);
        cycle(1, 0, 3'b000, 0, 1, '0, 1, '0, '0);
        idle(1, '0, '0);
        cycle(0, 0, 3'b000, 0, 0, '0, 1, '0, '0);
        idle(3, '0, '0);

        // R9: output enable removed while read data is held.
        tag = "R9";
        cycle(1, 0, SEL, 0, 0, 8'h21, 1, '0, '0);
        idle(1, '0, '0);
        cycle(1, 0, 3'b000, 0, 0, '0, 0, '0, '0);
        cycle(0, 0, 3'b000, 0, 0, '0, 0, '0, '0);
        cycle(0, 0, 3'b000, 0, 0, '0, 1, '0, '0);
        idle(3, '0, '0);

        // R10: write presented during sleep is ignored, then read back.
        tag = "R10";
        cycle(1, 0, SEL, 0, 0, 8'h20, 1, '0, '0);
        idle(1, '0, '0);
        cycle(1, 1, SEL, 1, 0, 8'h20, 1, rnd_word(), '1);
        cycle(1, 1, 3'b000, 0, 0, '0, 1, rnd_word(), '1);
        cycle(1, 1, 3'b000, 0, 0, '0, 1, rnd_word(), '1);
        idle(1, '0, '0);
        cycle(1, 0, SEL, 0, 0, 8'h20, 1, '0, '0);
        idle(3, '0, '0);

        // R11: reset while a read is in flight, contents survive.
        tag = "R11";
        cycle(1, 0, SEL, 0, 0, 8'h05, 1, '0, '0);
        rst_n = 1'b0; idle(1, '0, '0); rst_n = 1'b1;
        idle(3, '0, '0);
        cycle(1, 0, SEL, 0, 0, 8'h05, 1, '0, '0);
        idle(3, '0, '0);

        // R4: random mix, linear order.
        tag = "R4";
        for (int i = 0; i < 3000; i++) rand_cycle();
        idle(3, '0, '0);

        // R6: interleaved order from low bits 1 (1,0,3,2 then back to 1).
        do_reset(1);
        tag = "R6";
        cycle(1, 0, SEL, 0, 0, 8'h31, 1, '0, '0);
        for (int i = 0; i < 4; i++) cycle(1, 0, 3'b000, 0, 1, '0, 1, '0, '0);
        idle(3, '0, '0);
        tag = "R5";
        for (int i = 0; i < 3000; i++) rand_cycle();
        idle(3, '0, '0);

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog: cycles=100000 expected completion earlier");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule